// File: doc/BRIEF.md
# ADC Conversion and Clock Burst Sequencer

This block sits on the host side of a serial converter link. On each accepted sample request it drives a convert strobe for a fixed number of system cycles. It then waits until the converter's first header bit is guaranteed to be valid. After that it gates a burst of bit clocks whose count matches the result word. On the first cycle of the burst it raises a one-cycle marker, which lets the receive path start its alignment logic on the same edge.

All timing is counted in system clock cycles, and every limit is a parameter: `PULSE_W`, `PULSE_MAX`, `READY_WAIT`, `BURST_LEN`, `LEGACY_LEN` and `DEADLINE`. Elaboration fails when `PULSE_W` lies outside 1..`PULSE_MAX` or when `READY_WAIT` is not larger than `PULSE_W`.

A request that arrives while a conversion or its readout is in progress does not start a new conversion. If such a request lands during a burst that is still running `DEADLINE` cycles later, the data of the next conversion would be lost, so a sticky overrun flag is raised. Only reset clears the flag.

Top module: `adc_burst_seq`

## Requirements
- R1: After reset, `cnv`, `bclk`, `burst_start`, `busy` and `overrun` are all 0, and reset clears a set `overrun`.
- R2: An accepted request makes `cnv` high for exactly `PULSE_W` consecutive cycles (default 2). `cnv` is never high for more than `PULSE_MAX` cycles.
- R3: A `sample_req` seen while `cnv` is high, during the wait that follows, or during a burst starts no conversion.
- R4: The first `bclk` high cycle comes exactly `READY_WAIT` cycles after the first `cnv` high cycle (default 8). `burst_start` is high in that cycle only.
- R5: `bclk` is high for one cycle and then low for one cycle per pulse, never high in two adjacent cycles, and low whenever `busy` is 0.
- R6: A burst has `BURST_LEN` (18) pulses when `legacy_mode` was 0 at the accepting cycle, and `LEGACY_LEN` (19) when it was 1. Changes of `legacy_mode` during a conversion have no effect on it.
- R7: A request during a burst sets `overrun` if the burst is still running in the cycle `DEADLINE` cycles after the request cycle (default 6). Otherwise `overrun` is unchanged. `overrun` stays at 1 until reset.
- R8: A request in the single cycle right after the last low half of a burst is accepted, so `cnv` rises in the next cycle with `busy` held high.
- R9: `busy` is 1 from the first `cnv` cycle through the cycle after the burst ends, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Request to start a conversion, sampled every cycle |
| legacy_mode | input | 1 | Selects the longer burst, captured when a request is accepted |
| cnv | output | 1 | Convert strobe to the converter |
| bclk | output | 1 | Gated bit clock for the readout burst |
| burst_start | output | 1 | One-cycle marker on the first burst pulse |
| busy | output | 1 | Conversion or readout in progress |
| overrun | output | 1 | Sticky flag: burst missed the deadline of a new request |

## Verification
A wrong phase state or counter in this block shows up at the ports within one conversion. It appears as a strobe of the wrong width, a burst marker off its cycle, a pulse count off by one or doubled high cycles on the bit clock. A mis-decoded accept condition shows as an extra or missing strobe. That error is caught when the converted record is matched against the expected queue, no later than the next idle period. An error in the deadline counter appears as `overrun` on the wrong side of the exact boundary between request positions 29 and 30 in the burst.

// File: rtl/adc_burst_seq.sv
module adc_burst_seq #(
  parameter int PULSE_W    = 2,
  parameter int PULSE_MAX  = 4,
  parameter int READY_WAIT = 8,
  parameter int BURST_LEN  = 18,
  parameter int LEGACY_LEN = 19,
  parameter int DEADLINE   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_req,
  input  logic legacy_mode,
  output logic cnv,
  output logic bclk,
  output logic burst_start,
  output logic busy,
  output logic overrun
);

  localparam int CW = $clog2(READY_WAIT + LEGACY_LEN + BURST_LEN + PULSE_MAX + 2);
  localparam int DW = $clog2(DEADLINE + 2);
  localparam logic [CW-1:0] CNV_LAST  = CW'(PULSE_W - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(READY_WAIT - PULSE_W - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LEGACY_LEN - 1);
  localparam logic [DW-1:0] DL_LAST    = DW'(DEADLINE - 1);

  if (PULSE_W < 1 || PULSE_W > PULSE_MAX || READY_WAIT <= PULSE_W) begin : g_bad_params
    $error("adc_burst_seq: PULSE_W must be 1..PULSE_MAX and below READY_WAIT");
  end

  typedef enum logic [2:0] {S_IDLE, S_CNV, S_WAIT, S_BURST, S_DONE} state_t;

  state_t          st;
  logic [CW-1:0]   cnt;
  logic            ph;
  logic            long_q;
  logic            armed;
  logic [DW-1:0]   dl_cnt;

  wire accept     = sample_req && (st == S_IDLE || st == S_DONE);
  wire last_pulse = ph && (cnt == (long_q ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= 1'b0;
      long_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          cnt <= '0;
          ph  <= 1'b0;
          if (accept) begin
            st     <= S_CNV;
            long_q <= legacy_mode;
          end else begin
            st <= S_IDLE;
          end
        end
        S_CNV: begin
          if (cnt == CNV_LAST) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == WAIT_LAST) begin
            st  <= S_BURST;
            cnt <= '0;
            ph  <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BURST: begin
          ph <= ~ph;
          if (last_pulse) begin
            st  <= S_DONE;
            cnt <= '0;
          end else if (ph) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dl_cnt  <= '0;
      overrun <= 1'b0;
    end else if (st != S_BURST) begin
      armed  <= 1'b0;
      dl_cnt <= '0;
    end else if (armed) begin
      if (dl_cnt == DL_LAST) overrun <= 1'b1;
      if (dl_cnt != DL_LAST) dl_cnt <= dl_cnt + 1'b1;
    end else if (sample_req) begin
      armed  <= 1'b1;
      dl_cnt <= '0;
    end
  end

  assign cnv         = (st == S_CNV);
  assign bclk        = (st == S_BURST) && !ph;
  assign burst_start = bclk && (cnt == '0);
  assign busy        = (st != S_IDLE);

endmodule

// File: rtl/adc_burst_seq_chk.sv
module adc_burst_seq_chk #(
  parameter int PULSE_MAX = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cnv,
  input logic bclk,
  input logic burst_start,
  input logic busy,
  input logic overrun
);

  logic [7:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)   hi_run <= '0;
    else if (cnv) hi_run <= (hi_run == 8'hff) ? hi_run : hi_run + 8'd1;
    else          hi_run <= '0;
  end

  a_r2_cnv_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnv |-> (hi_run < 8'(PULSE_MAX)));

  a_r5_bclk_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    bclk |=> !bclk);

  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bclk && !cnv && !burst_start));

  a_r3_no_cnv_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    bclk |-> !cnv);

  a_r4_marker_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> bclk);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r9_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv || bclk) |-> busy);

endmodule

bind adc_burst_seq adc_burst_seq_chk #(.PULSE_MAX(PULSE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv(cnv), .bclk(bclk),
  .burst_start(burst_start), .busy(busy), .overrun(overrun)
);

// File: tb/tb_adc_burst_seq.sv
`timescale 1ns/1ps
module tb_adc_burst_seq;

  localparam int PW  = 2;
  localparam int RW  = 8;
  localparam int NL  = 18;
  localparam int LL  = 19;
  localparam int DLN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_req = 1'b0;
  logic legacy_mode = 1'b0;
  logic cnv, bclk, burst_start, busy, overrun;

  always #2 clk = ~clk;

  adc_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .legacy_mode(legacy_mode),
    .cnv(cnv), .bclk(bclk), .burst_start(burst_start), .busy(busy), .overrun(overrun)
  );

  typedef struct { int width; int offset; int pulses; } rec_t;
  rec_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor
  int cyc = 0, t0 = 0, w = 0, off = -1, np = 0;
  bit open = 0, p_cnv = 0, p_bclk = 0, p_busy = 0;

  task automatic finalize();
    rec_t e;
    if (exp_q.size() == 0) begin
      check(0, "R3 unexpected conversion", 1, 0);
    end else begin
      e = exp_q.pop_front();
      check(w == e.width, "R2 cnv width", w, e.width);
      check(off == e.offset, "R4 burst offset", off, e.offset);
      check(np == e.pulses, "R6 pulse count", np, e.pulses);
    end
    open = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cnv = 0; p_bclk = 0; p_busy = 0; open = 0;
    end else begin
      cyc++;
      if (cnv && !p_cnv) begin
        if (open) finalize();
        open = 1; t0 = cyc; w = 0; off = -1; np = 0;
        check(busy, "R9 busy at cnv rise", busy, 1);
      end
      if (cnv) w++;
      if (burst_start) begin
        if (off < 0) off = cyc - t0;
        else check(0, "R4 second burst_start", cyc - t0, off);
      end
      if (bclk) begin
        np++;
        if (p_bclk) check(0, "R5 bclk high twice", 1, 0);
        if (!busy) check(0, "R5 bclk while idle", 1, 0);
      end
      if (!busy && p_busy && open) finalize();
      p_cnv = cnv; p_bclk = bclk; p_busy = busy;
    end
  end

  task automatic push(input int pulses);
    rec_t r;
    r.width = PW; r.offset = RW; r.pulses = pulses;
    exp_q.push_back(r);
  endtask

  // request held through most of the conversion phase: only first edge may count (R3)
  task automatic start_conv(input bit legacy);
    push(legacy ? LL : NL);
    legacy_mode = legacy;
    sample_req = 1'b1;
    repeat (6) @(negedge clk);
    sample_req = 1'b0;
    legacy_mode = ~legacy;
  endtask

  task automatic req_in_burst(input int j);
    while (!burst_start) @(negedge clk);
    repeat (j) @(negedge clk);
    sample_req = 1'b1;
    @(negedge clk);
    sample_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!cnv, "R1 cnv reset", cnv, 0);
    check(!bclk, "R1 bclk reset", bclk, 0);
    check(!burst_start, "R1 burst_start reset", burst_start, 0);
    check(!busy, "R1 busy reset", busy, 0);
    check(!overrun, "R1 overrun reset", overrun, 0);
    rst_n = 1'b1;
    @(negedge clk);

    start_conv(1'b0);
    wait_idle();

    start_conv(1'b1);              // R6 legacy, flipped after accept
    wait_idle();

    start_conv(1'b0);              // R8 back-to-back from done cycle
    push(NL);
    legacy_mode = 1'b0;
    req_in_burst(2 * NL);
    wait_idle();
    check(!overrun, "R8 no overrun back-to-back", overrun, 0);

    start_conv(1'b0);              // R7 boundary: no overrun
    req_in_burst(2 * NL - DLN);
    wait_idle();
    check(!overrun, "R7 late request no overrun", overrun, 0);

    start_conv(1'b0);              // R7 boundary: overrun
    req_in_burst(2 * NL - DLN - 1);
    wait_idle();
    check(overrun, "R7 early request overrun", overrun, 1);

    start_conv(1'b0);
    wait_idle();
    check(overrun, "R7 overrun sticky", overrun, 1);

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!overrun, "R1 reset clears overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check(exp_q.size() == 0, "R3 missing conversions", exp_q.size(), 0);
    check(!open, "R9 record left open", open, 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R9 watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule